// File: doc/BRIEF.md
# USB OUT Endpoint Transaction Handler

This block is the device-side controller for the OUT transactions of a small set of endpoints. A packet decoder gives it token fields (PID, device address, endpoint number) and then the data phase as a byte stream. The stream ends with an end-of-packet strobe that is either good or bad. The handler decides whether the token concerns this device. It then stores the payload in the endpoint's buffer or refuses it, and it chooses the handshake that goes back to the host. It also keeps per-endpoint status for a local microprocessor: buffer full, last-transfer-good and received length. It has an interrupt register that is cleared when read.

The microprocessor works from the interrupt register. It reads the endpoint's status and stored bytes, and it releases the buffer with a clear strobe. Isochronous endpoints never send a handshake and commit as soon as good data has arrived.

The controller has four states. IDLE waits for a token. RECV stores data bytes. REFUSE lets the data of a full endpoint pass unstored. DROP discards the rest of a packet that overran the buffer. The transitions are:
- IDLE to RECV on a matching token to an empty endpoint.
- IDLE to REFUSE on a matching token to a full endpoint.
- RECV to DROP on a byte beyond the buffer depth.
- RECV, REFUSE or DROP back to IDLE on any end-of-packet, good or bad.

Top module: `usb_oute_ctrl`

## Requirements
- R1: After reset, hs_valid, int_reg, irq, buf_full, ltr and every rx_len field are zero.
- R2: A token counts only when tok_valid is high, tok_pid is 4'b0001 (OUT), tok_addr equals dev_addr, tok_ep is below 4 and ep_en[tok_ep] is 1. Any other token is ignored, and its data and end-of-packet produce no handshake and no status change.
- R3: For a counted token to an empty non-isochronous endpoint, byte k of the data phase is stored at index k. On a good end-of-packet the outputs change at the clock edge that samples it. hs_valid pulses with hs_pid 4'b0010 (ACK), and buf_full, ltr and int_reg set the endpoint's bit. rx_len field (bits 7*e+6 down to 7*e) takes the byte count.
- R4: A counted token to an endpoint whose buffer_full bit is set stores nothing. It leaves rx_len unchanged, and on a good end-of-packet of a non-isochronous endpoint it answers hs_pid 4'b1010 (NAK).
- R5: Isochronous endpoints (ep_iso bit 1) never produce hs_valid. On a good end-of-packet to an empty isochronous buffer they update buf_full, ltr, int_reg and rx_len as in R3.
- R6: A data phase that ends with rx_eop_err gives no handshake and leaves buf_full, ltr, int_reg and rx_len unchanged.
- R7: A data phase of more than 64 bytes is treated as an error (no handshake, no status change). Exactly 64 bytes is accepted.
- R8: irq is the OR of int_reg. An int_rd pulse clears the bits set before that edge. A bit set by a commit at the same edge stays set.
- R9: clr_valid clears buf_full and ltr of endpoint clr_ep, so that the next OUT to it is accepted.
- R10: hs_valid lasts exactly one cycle per handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dev_addr | input | 7 | This device's assigned address |
| ep_en | input | 4 | Per-endpoint enable |
| ep_iso | input | 4 | Per-endpoint isochronous flag |
| tok_valid | input | 1 | Token fields valid strobe |
| tok_pid | input | 4 | Decoded token PID |
| tok_addr | input | 7 | Token device address |
| tok_ep | input | 4 | Token endpoint number |
| rx_valid | input | 1 | Data byte strobe |
| rx_byte | input | 8 | Data byte |
| rx_eop_ok | input | 1 | End of data packet, no error |
| rx_eop_err | input | 1 | End of data packet with CRC or stuffing error |
| hs_valid | output | 1 | Handshake request pulse |
| hs_pid | output | 4 | Handshake PID (ACK or NAK) |
| int_reg | output | 4 | Interrupt bits, one per endpoint |
| int_rd | input | 1 | Interrupt register read strobe (clears) |
| irq | output | 1 | Interrupt line |
| buf_full | output | 4 | Buffer-full flag per endpoint |
| ltr | output | 4 | Last transfer received good, per endpoint |
| clr_valid | input | 1 | Buffer release strobe |
| clr_ep | input | 2 | Endpoint to release |
| rd_ep | input | 2 | Buffer read endpoint select |
| rd_idx | input | 6 | Buffer read byte index |
| rd_byte | output | 8 | Buffer read data |
| rx_len | output | 28 | Received byte count, 7 bits per endpoint |

## Verification
On every cycle the bound checker confirms several properties of the handshake and status outputs:
- A handshake is a single-cycle ACK or NAK that only follows a good end-of-packet.
- A buffer only becomes full after a good end-of-packet, and a NAK never coincides with a buffer filling.
- A new interrupt bit always comes with its buffer becoming full, and the interrupt line falls only after a register read.

The directed scenarios show what needs whole transactions to observe:
- Address, PID, endpoint-range and enable filtering.
- The stored byte contents and lengths, including the 64-byte boundary and the 65-byte overrun.
- Isochronous silence and refusals of full buffers.
- Release through the clear strobe, and the case where a set and a read land on the same edge.

// File: rtl/usb_oute_pkg.sv
package usb_oute_pkg;
    localparam logic [3:0] PID_OUT = 4'b0001;
    localparam logic [3:0] PID_ACK = 4'b0010;
    localparam logic [3:0] PID_NAK = 4'b1010;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RECV,
        ST_REFUSE,
        ST_DROP
    } oute_state_e;
endpackage

// File: rtl/usb_oute_tokchk.sv
module usb_oute_tokchk
    import usb_oute_pkg::*;
#(
    parameter int NUM_EP   = 4,
    parameter int ADDR_W   = 7,
    parameter int EP_IDX_W = 2
) (
    input  logic                tok_valid,
    input  logic [3:0]          tok_pid,
    input  logic [ADDR_W-1:0]   tok_addr,
    input  logic [3:0]          tok_ep,
    input  logic [ADDR_W-1:0]   dev_addr,
    input  logic [NUM_EP-1:0]   ep_en,
    output logic                hit,
    output logic [EP_IDX_W-1:0] ep_idx
);
    localparam logic [3:0] EP_LIMIT = 4'(NUM_EP);

    always_comb begin
        hit    = 1'b0;
        ep_idx = tok_ep[EP_IDX_W-1:0];
        // Token must be OUT, for this address, for an existing and enabled endpoint
        if (tok_valid && (tok_pid == PID_OUT) && (tok_addr == dev_addr)
            && (tok_ep < EP_LIMIT)) begin
            hit = ep_en[ep_idx];
        end
    end
endmodule

// File: rtl/usb_oute_bufmem.sv
module usb_oute_bufmem #(
    parameter int NUM_EP   = 4,
    parameter int DEPTH    = 64,
    parameter int EP_IDX_W = 2,
    parameter int IDX_W    = 6
) (
    input  logic                clk,
    input  logic                wr_en,
    input  logic [EP_IDX_W-1:0] wr_ep,
    input  logic [IDX_W-1:0]    wr_idx,
    input  logic [7:0]          wr_byte,
    input  logic [EP_IDX_W-1:0] rd_ep,
    input  logic [IDX_W-1:0]    rd_idx,
    output logic [7:0]          rd_byte
);
    logic [7:0] bank_out [NUM_EP];

    for (genvar e = 0; e < NUM_EP; e++) begin : g_bank
        logic [7:0] bank [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en && (wr_ep == EP_IDX_W'(e))) begin
                bank[wr_idx] <= wr_byte;
            end
        end

        assign bank_out[e] = bank[rd_idx];
    end

    assign rd_byte = bank_out[rd_ep];
endmodule

// File: rtl/usb_oute_epstat.sv
module usb_oute_epstat #(
    parameter int NUM_EP   = 4,
    parameter int EP_IDX_W = 2,
    parameter int LEN_W    = 7
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    commit,
    input  logic [EP_IDX_W-1:0]     commit_ep,
    input  logic [LEN_W-1:0]        commit_len,
    input  logic                    clr_valid,
    input  logic [EP_IDX_W-1:0]     clr_ep,
    input  logic                    int_rd,
    output logic [NUM_EP-1:0]       buf_full,
    output logic [NUM_EP-1:0]       ltr,
    output logic [NUM_EP-1:0]       int_bits,
    output logic [NUM_EP*LEN_W-1:0] rx_len
);
    for (genvar e = 0; e < NUM_EP; e++) begin : g_ep
        logic             full_q;
        logic             ltr_q;
        logic             int_q;
        logic [LEN_W-1:0] len_q;
        logic             set_e;
        logic             clr_e;

        assign set_e = commit && (commit_ep == EP_IDX_W'(e));
        assign clr_e = clr_valid && (clr_ep == EP_IDX_W'(e));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                full_q <= 1'b0;
                ltr_q  <= 1'b0;
                len_q  <= '0;
            end else if (set_e) begin
                full_q <= 1'b1;
                ltr_q  <= 1'b1;
                len_q  <= commit_len;
            end else if (clr_e) begin
                full_q <= 1'b0;
                ltr_q  <= 1'b0;
            end
        end

        // A new event wins over a read in the same cycle
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                int_q <= 1'b0;
            end else if (set_e) begin
                int_q <= 1'b1;
            end else if (int_rd) begin
                int_q <= 1'b0;
            end
        end

        assign buf_full[e]              = full_q;
        assign ltr[e]                   = ltr_q;
        assign int_bits[e]              = int_q;
        assign rx_len[e*LEN_W +: LEN_W] = len_q;
    end
endmodule

// File: rtl/usb_oute_ctrl.sv
module usb_oute_ctrl
    import usb_oute_pkg::*;
#(
    parameter int NUM_EP    = 4,
    parameter int BUF_DEPTH = 64,
    parameter int ADDR_W    = 7,
    localparam int EP_IDX_W = $clog2(NUM_EP),
    localparam int IDX_W    = $clog2(BUF_DEPTH),
    localparam int LEN_W    = $clog2(BUF_DEPTH + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       dev_addr,
    input  logic [NUM_EP-1:0]       ep_en,
    input  logic [NUM_EP-1:0]       ep_iso,
    input  logic                    tok_valid,
    input  logic [3:0]              tok_pid,
    input  logic [ADDR_W-1:0]       tok_addr,
    input  logic [3:0]              tok_ep,
    input  logic                    rx_valid,
    input  logic [7:0]              rx_byte,
    input  logic                    rx_eop_ok,
    input  logic                    rx_eop_err,
    output logic                    hs_valid,
    output logic [3:0]              hs_pid,
    output logic [NUM_EP-1:0]       int_reg,
    input  logic                    int_rd,
    output logic                    irq,
    output logic [NUM_EP-1:0]       buf_full,
    output logic [NUM_EP-1:0]       ltr,
    input  logic                    clr_valid,
    input  logic [EP_IDX_W-1:0]     clr_ep,
    input  logic [EP_IDX_W-1:0]     rd_ep,
    input  logic [IDX_W-1:0]        rd_idx,
    output logic [7:0]              rd_byte,
    output logic [NUM_EP*LEN_W-1:0] rx_len
);
    localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(BUF_DEPTH);

    oute_state_e         state_q, state_d;
    logic                tok_hit;
    logic [EP_IDX_W-1:0] tok_idx;
    logic [EP_IDX_W-1:0] cur_ep_q;
    logic [LEN_W-1:0]    cnt_q;
    logic                eop_any;
    logic                wr_en;
    logic                commit;
    logic                cur_iso;

    usb_oute_tokchk #(
        .NUM_EP   (NUM_EP),
        .ADDR_W   (ADDR_W),
        .EP_IDX_W (EP_IDX_W)
    ) u_tokchk (
        .tok_valid (tok_valid),
        .tok_pid   (tok_pid),
        .tok_addr  (tok_addr),
        .tok_ep    (tok_ep),
        .dev_addr  (dev_addr),
        .ep_en     (ep_en),
        .hit       (tok_hit),
        .ep_idx    (tok_idx)
    );

    assign eop_any = rx_eop_ok || rx_eop_err;
    assign cur_iso = ep_iso[cur_ep_q];
    assign wr_en   = (state_q == ST_RECV) && rx_valid && (cnt_q != LEN_MAX);
    assign commit  = (state_q == ST_RECV) && rx_eop_ok;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (tok_hit) begin
                    state_d = buf_full[tok_idx] ? ST_REFUSE : ST_RECV;
                end
            end
            ST_RECV: begin
                if (eop_any) begin
                    state_d = ST_IDLE;
                end else if (rx_valid && (cnt_q == LEN_MAX)) begin
                    state_d = ST_DROP;
                end
            end
            ST_REFUSE: begin
                if (eop_any) state_d = ST_IDLE;
            end
            ST_DROP: begin
                if (eop_any) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Registered outputs and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_ep_q <= '0;
            cnt_q    <= '0;
            hs_valid <= 1'b0;
            hs_pid   <= 4'b0000;
        end else begin
            hs_valid <= 1'b0;
            if ((state_q == ST_IDLE) && tok_hit) begin
                cur_ep_q <= tok_idx;
                cnt_q    <= '0;
            end else if (wr_en) begin
                cnt_q <= cnt_q + 1'b1;
            end
            if (rx_eop_ok && !cur_iso) begin
                if (state_q == ST_RECV) begin
                    hs_valid <= 1'b1;
                    hs_pid   <= PID_ACK;
                end else if (state_q == ST_REFUSE) begin
                    hs_valid <= 1'b1;
                    hs_pid   <= PID_NAK;
                end
            end
        end
    end

    usb_oute_bufmem #(
        .NUM_EP   (NUM_EP),
        .DEPTH    (BUF_DEPTH),
        .EP_IDX_W (EP_IDX_W),
        .IDX_W    (IDX_W)
    ) u_bufmem (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_ep   (cur_ep_q),
        .wr_idx  (cnt_q[IDX_W-1:0]),
        .wr_byte (rx_byte),
        .rd_ep   (rd_ep),
        .rd_idx  (rd_idx),
        .rd_byte (rd_byte)
    );

    usb_oute_epstat #(
        .NUM_EP   (NUM_EP),
        .EP_IDX_W (EP_IDX_W),
        .LEN_W    (LEN_W)
    ) u_epstat (
        .clk        (clk),
        .rst_n      (rst_n),
        .commit     (commit),
        .commit_ep  (cur_ep_q),
        .commit_len (cnt_q),
        .clr_valid  (clr_valid),
        .clr_ep     (clr_ep),
        .int_rd     (int_rd),
        .buf_full   (buf_full),
        .ltr        (ltr),
        .int_bits   (int_reg),
        .rx_len     (rx_len)
    );

    assign irq = |int_reg;
endmodule

// File: rtl/usb_oute_chk.sv
module usb_oute_chk
    import usb_oute_pkg::*;
#(
    parameter int NUM_EP = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hs_valid,
    input logic [3:0]        hs_pid,
    input logic              rx_eop_ok,
    input logic              int_rd,
    input logic              irq,
    input logic [NUM_EP-1:0] int_reg,
    input logic [NUM_EP-1:0] buf_full
);
    // R10
    hs_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hs_valid |=> !hs_valid);

    // R3
    hs_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hs_valid |-> ((hs_pid == PID_ACK) || (hs_pid == PID_NAK)));

    // R6
    hs_after_good_eop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hs_valid |-> $past(rx_eop_ok));

    // R3
    fill_after_good_eop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((buf_full & ~$past(buf_full)) != '0) |-> $past(rx_eop_ok));

    // R4
    nak_no_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_valid && (hs_pid == PID_NAK)) |-> ((buf_full & ~$past(buf_full)) == '0));

    // R5
    int_with_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((int_reg & ~$past(int_reg) & ~(buf_full & ~$past(buf_full))) == '0));

    // R8
    irq_fall_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(int_rd));
endmodule

bind usb_oute_ctrl usb_oute_chk #(.NUM_EP(NUM_EP)) u_oute_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .hs_valid  (hs_valid),
    .hs_pid    (hs_pid),
    .rx_eop_ok (rx_eop_ok),
    .int_rd    (int_rd),
    .irq       (irq),
    .int_reg   (int_reg),
    .buf_full  (buf_full)
);

// File: tb/tb_usb_oute_ctrl.sv
module tb_usb_oute_ctrl;
    localparam int MAX_CYC = 200000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  dev_addr = 7'h2A;
    logic [3:0]  ep_en = 4'b1111;
    logic [3:0]  ep_iso = 4'b0100;
    logic        tok_valid = 1'b0;
    logic [3:0]  tok_pid = 4'b0000;
    logic [6:0]  tok_addr = 7'h00;
    logic [3:0]  tok_ep = 4'd0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = 8'h00;
    logic        rx_eop_ok = 1'b0;
    logic        rx_eop_err = 1'b0;
    logic        hs_valid;
    logic [3:0]  hs_pid;
    logic [3:0]  int_reg;
    logic        int_rd = 1'b0;
    logic        irq;
    logic [3:0]  buf_full;
    logic [3:0]  ltr;
    logic        clr_valid = 1'b0;
    logic [1:0]  clr_ep = 2'd0;
    logic [1:0]  rd_ep = 2'd0;
    logic [5:0]  rd_idx = 6'd0;
    logic [7:0]  rd_byte;
    logic [27:0] rx_len;

    int n_chk = 0;
    int n_err = 0;

    usb_oute_ctrl dut (
        .clk(clk), .rst_n(rst_n), .dev_addr(dev_addr), .ep_en(ep_en), .ep_iso(ep_iso),
        .tok_valid(tok_valid), .tok_pid(tok_pid), .tok_addr(tok_addr), .tok_ep(tok_ep),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_eop_ok(rx_eop_ok), .rx_eop_err(rx_eop_err),
        .hs_valid(hs_valid), .hs_pid(hs_pid), .int_reg(int_reg), .int_rd(int_rd), .irq(irq),
        .buf_full(buf_full), .ltr(ltr), .clr_valid(clr_valid), .clr_ep(clr_ep),
        .rd_ep(rd_ep), .rd_idx(rd_idx), .rd_byte(rd_byte), .rx_len(rx_len)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int len_of(input int e);
        return int'(rx_len[e*7 +: 7]);
    endfunction

    task automatic send_tok(input logic [3:0] pid, input logic [6:0] addr, input logic [3:0] ep);
        @(negedge clk);
        tok_valid = 1'b1; tok_pid = pid; tok_addr = addr; tok_ep = ep;
        @(negedge clk);
        tok_valid = 1'b0;
    endtask

    task automatic send_bytes(input int n, input int seed);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rx_valid = 1'b1; rx_byte = 8'(seed + i);
        end
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic end_pkt(input logic ok, input logic rd);
        @(negedge clk);
        rx_eop_ok = ok; rx_eop_err = !ok; int_rd = rd;
        @(negedge clk);
        rx_eop_ok = 1'b0; rx_eop_err = 1'b0; int_rd = 1'b0;
    endtask

    task automatic xfer(input logic [3:0] pid, input logic [6:0] addr, input logic [3:0] ep,
                        input int n, input int seed, input logic ok, input logic rd);
        send_tok(pid, addr, ep);
        send_bytes(n, seed);
        end_pkt(ok, rd);
    endtask

    // Called at the negedge right after the end-of-packet edge
    task automatic check_hs(input string req, input logic exp_v, input logic [3:0] exp_pid);
        chk({req, " hs_valid"}, int'(hs_valid), int'(exp_v));
        if (exp_v) chk({req, " hs_pid"}, int'(hs_pid), int'(exp_pid));
        @(negedge clk);
        chk("R10 hs_valid drops after one cycle", int'(hs_valid), 0);
    endtask

    task automatic check_byte(input string req, input int ep, input int idx, input int exp);
        rd_ep = 2'(ep); rd_idx = 6'(idx);
        #1;
        chk(req, int'(rd_byte), exp);
    endtask

    task automatic read_int(input string req, input int exp);
        @(negedge clk);
        chk(req, int'(int_reg), exp);
        int_rd = 1'b1;
        @(negedge clk);
        int_rd = 1'b0;
    endtask

    task automatic release_buf(input int ep);
        @(negedge clk);
        clr_valid = 1'b1; clr_ep = 2'(ep);
        @(negedge clk);
        clr_valid = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 hs_valid", int'(hs_valid), 0);
        chk("R1 int_reg", int'(int_reg), 0);
        chk("R1 irq", int'(irq), 0);
        chk("R1 buf_full", int'(buf_full), 0);
        chk("R1 ltr", int'(ltr), 0);
        chk("R1 rx_len", int'(rx_len), 0);
    endtask

    task automatic t_ignore;
        xfer(4'b1001, 7'h2A, 4'd1, 3, 8'h20, 1'b1, 1'b0);
        check_hs("R2 wrong pid", 1'b0, 4'b0000);
        xfer(4'b0001, 7'h2B, 4'd1, 3, 8'h20, 1'b1, 1'b0);
        check_hs("R2 wrong address", 1'b0, 4'b0000);
        xfer(4'b0001, 7'h2A, 4'd5, 3, 8'h20, 1'b1, 1'b0);
        check_hs("R2 endpoint out of range", 1'b0, 4'b0000);
        ep_en = 4'b1101;
        xfer(4'b0001, 7'h2A, 4'd1, 3, 8'h20, 1'b1, 1'b0);
        check_hs("R2 disabled endpoint", 1'b0, 4'b0000);
        ep_en = 4'b1111;
        chk("R2 buf_full untouched", int'(buf_full), 0);
        chk("R2 int_reg untouched", int'(int_reg), 0);
        chk("R2 rx_len untouched", int'(rx_len), 0);
    endtask

    task automatic t_accept;
        xfer(4'b0001, 7'h2A, 4'd1, 5, 8'h10, 1'b1, 1'b0);
        chk("R3 buf_full set", int'(buf_full), 4'b0010);
        chk("R3 ltr set", int'(ltr), 4'b0010);
        chk("R3 int_reg set", int'(int_reg), 4'b0010);
        chk("R8 irq high", int'(irq), 1);
        chk("R3 rx_len", len_of(1), 5);
        check_hs("R3 ACK", 1'b1, 4'b0010);
        check_byte("R3 byte 0", 1, 0, 8'h10);
        check_byte("R3 byte 4", 1, 4, 8'h14);
    endtask

    task automatic t_nak;
        xfer(4'b0001, 7'h2A, 4'd1, 3, 8'h80, 1'b1, 1'b0);
        chk("R4 rx_len kept", len_of(1), 5);
        chk("R4 buf_full kept", int'(buf_full), 4'b0010);
        check_hs("R4 NAK", 1'b1, 4'b1010);
        check_byte("R4 byte 0 not overwritten", 1, 0, 8'h10);
    endtask

    task automatic t_intread;
        read_int("R8 read value", 4'b0010);
        chk("R8 cleared by read", int'(int_reg), 0);
        chk("R8 irq low", int'(irq), 0);
        chk("R8 buf_full survives read", int'(buf_full), 4'b0010);
    endtask

    task automatic t_release;
        release_buf(1);
        chk("R9 buf_full cleared", int'(buf_full), 0);
        chk("R9 ltr cleared", int'(ltr), 0);
        xfer(4'b0001, 7'h2A, 4'd1, 2, 8'h40, 1'b1, 1'b0);
        chk("R9 rx_len after re-accept", len_of(1), 2);
        check_hs("R9 ACK after release", 1'b1, 4'b0010);
        check_byte("R9 new byte 0", 1, 0, 8'h40);
        read_int("R9 int after re-accept", 4'b0010);
    endtask

    task automatic t_iso;
        xfer(4'b0001, 7'h2A, 4'd2, 4, 8'h30, 1'b1, 1'b0);
        chk("R5 iso buf_full", int'(buf_full[2]), 1);
        chk("R5 iso int", int'(int_reg), 4'b0100);
        chk("R5 iso rx_len", len_of(2), 4);
        check_hs("R5 iso no handshake", 1'b0, 4'b0000);
        xfer(4'b0001, 7'h2A, 4'd2, 6, 8'h90, 1'b1, 1'b0);
        chk("R5 full iso rx_len kept", len_of(2), 4);
        check_hs("R5 full iso no handshake", 1'b0, 4'b0000);
    endtask

    task automatic t_err;
        xfer(4'b0001, 7'h2A, 4'd3, 6, 8'h50, 1'b0, 1'b0);
        chk("R6 buf_full unchanged", int'(buf_full[3]), 0);
        chk("R6 int unchanged", int'(int_reg[3]), 0);
        chk("R6 rx_len unchanged", len_of(3), 0);
        check_hs("R6 no handshake on error", 1'b0, 4'b0000);
    endtask

    task automatic t_overrun;
        xfer(4'b0001, 7'h2A, 4'd0, 65, 8'h00, 1'b1, 1'b0);
        chk("R7 overrun buf_full", int'(buf_full[0]), 0);
        chk("R7 overrun rx_len", len_of(0), 0);
        check_hs("R7 overrun no handshake", 1'b0, 4'b0000);
        xfer(4'b0001, 7'h2A, 4'd0, 64, 8'h01, 1'b1, 1'b0);
        chk("R7 64 bytes rx_len", len_of(0), 64);
        check_hs("R7 64 bytes ACK", 1'b1, 4'b0010);
        check_byte("R7 last byte", 0, 63, 8'h40);
    endtask

    task automatic t_setwins;
        chk("R8 pending bits", int'(int_reg), 4'b0101);
        xfer(4'b0001, 7'h2A, 4'd3, 2, 8'h60, 1'b1, 1'b1);
        chk("R8 set beats read", int'(int_reg), 4'b1000);
        check_hs("R8 ACK during read", 1'b1, 4'b0010);
    endtask

    initial begin
        repeat (MAX_CYC) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired (all requirements)");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ignore();
        t_accept();
        t_nak();
        t_intread();
        t_release();
        t_iso();
        t_err();
        t_overrun();
        t_setwins();
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule